// File: doc/BRIEF.md
# USB Root Port Status and Control Register

This block is one root port's status and control word for a USB host controller. Software reaches it through a plain 32-bit write port and a read port. The word carries several kinds of field. Some are live status: connect, over-current, port enable, speed and link state. Some are controls: reset, warm reset, power and the three wake enables. The rest are seven sticky change flags.

Hardware supplies four inputs:

- raw connect and over-current detect levels, each passed through a small synchroniser;
- a link-state report with an update strobe;
- the speed the link negotiated;
- a configure-error strobe.

An internal reset timer ends a reset with a completion strobe.

The change flags latch hardware events until software clears them by writing 1 to them. A single `port_change` output is high while any of these flags is set. An interrupt or event generator uses this output to notice that the port needs service.

Top module: `rport_ctrl`

## Requirements
- R1: After reset the read word is 0x0000_02A0: power (bit 9) is 1, the link state (bits 8:5) is 5 and every other bit is 0. `port_change` is 0.
- R2: Bit 0 takes the value `hw_connect` had two rising edges earlier. On the edge where bit 0 changes, the connect change flag (bit 17) sets.
- R3: Bit 3 takes the value `hw_overcur` had two edges earlier. Any change of bit 3 sets bit 20.
- R4: A write with bit 4 = 1, made while power (bit 9) reads 1, sets the reset bit (bit 4). The bit then stays 1 until the edge that sees `reset_done` high. On that edge bit 4 clears, bit 21 sets, and bit 1 (enable) sets if the port is connected. A write of bit 4 while power reads 0 is ignored.
- R5: At reset completion the speed field (bits 13:10) loads `hw_speed` when that value is 0 to 4 (1 full, 2 low, 3 high, 4 super). A reserved value from 5 to 15 loads 0. A disconnect clears the field to 0.
- R6: A software write changes the link state (bits 8:5) only when bit 16 is 1 in the same write. Bit 16 reads 0. A `link_upd` pulse loads `hw_link_state` and sets bit 22. When both happen in the same cycle, the hardware update wins.
- R7: Writing bit 31 = 1 while powered sets both bit 31 and bit 4. At reset completion both clear and bits 19 and 21 set.
- R8: The enable bit falls on any of three events: a disconnect, a rising over-current, or a write of bit 9 = 0. Each such fall sets bit 18.
- R9: The flags in bits 23:17 clear when 1 is written to them. Writing 0 leaves them unchanged. A hardware set in the same cycle as a clear wins. A `cfg_err` pulse sets bit 23.
- R10: `port_change` is 1 exactly while any of bits 23:17 is 1. It reads 0 in the cycle after the write that clears the last set flag.
- R11: Bit 9 and bits 27:25 are read/write. Bits 2, 15:14, 16, 24 and 30:28 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register value |
| hw_connect | input | 1 | Raw device connect detect |
| hw_overcur | input | 1 | Raw over-current detect |
| hw_link_state | input | 4 | Link state reported by the link layer |
| link_upd | input | 1 | Strobe loading hw_link_state |
| hw_speed | input | 4 | Negotiated device speed |
| reset_done | input | 1 | Reset timer completion strobe |
| cfg_err | input | 1 | Link partner configure error strobe |
| port_change | output | 1 | High while any change flag is set |

## Verification
Each stimulus pattern is aimed at telling one behaviour apart from its neighbours.

- Connect and over-current toggles separate the two-stage input delay from the edge on which each flag sets.
- A normal reset and a warm reset differ only in which completion flags they raise.
- Reset completion is driven with both a legal speed and a reserved speed, which exposes the clamp.
- Link-state writes are made with and without the strobe bit, and once together with a hardware update, to pin down the write gate and the priority.
- Flag writes of 0, a clear that collides with a hardware set, and a final clear of all flags show the write-1-to-clear rule and the timing of `port_change`.

// File: rtl/rport_pkg.sv
`timescale 1ns/1ps
package rport_pkg;
   localparam int DW        = 32;
   localparam int B_CONN    = 0;
   localparam int B_EN      = 1;
   localparam int B_OC      = 3;
   localparam int B_PR      = 4;
   localparam int B_LNK_LO  = 5;
   localparam int LNK_W     = 4;
   localparam int B_PWR     = 9;
   localparam int B_SPD_LO  = 10;
   localparam int SPD_W     = 4;
   localparam int B_LSTB    = 16;
   localparam int B_CHG_LO  = 17;
   localparam int N_CHG     = 7;
   localparam int B_WAKE_LO = 25;
   localparam int N_WAKE    = 3;
   localparam int B_WARM    = 31;

   // change flag index, bit position = B_CHG_LO + index
   typedef enum logic [2:0] {
      CHG_CONN = 3'd0,
      CHG_EN   = 3'd1,
      CHG_WARM = 3'd2,
      CHG_OC   = 3'd3,
      CHG_RST  = 3'd4,
      CHG_LINK = 3'd5,
      CHG_CFG  = 3'd6
   } chg_e;
endpackage

// File: rtl/rport_sync.sv
`timescale 1ns/1ps
module rport_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic q_next
);
   if (STAGES < 1) begin : g_bad
      $error("rport_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= RST_VAL;
         else        q <= d;
      end
      assign q_next = d;
   end else begin : g_chain
      logic [STAGES-1:0] st;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st <= {STAGES{RST_VAL}};
         else        st <= {st[STAGES-2:0], d};
      end
      assign q      = st[STAGES-1];
      assign q_next = st[STAGES-2];
   end
endmodule

// File: rtl/rport_chg.sv
`timescale 1ns/1ps
module rport_chg #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags,
   output logic         any
);
   if (N < 1) begin : g_bad
      $error("rport_chg: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic f;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) f <= 1'b0;
         else        f <= set[i] | (f & ~clr[i]);
      end
      assign flags[i] = f;
   end

   assign any = |flags;
endmodule

// File: rtl/rport_rstctl.sv
`timescale 1ns/1ps
module rport_rstctl
   import rport_pkg::*;
#(
   parameter int SPEED_MAX = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conn_q,
   input  logic             conn_d,
   input  logic             oc_q,
   input  logic             oc_d,
   input  logic             pwr_off,
   input  logic             start_pr,
   input  logic             start_warm,
   input  logic             rst_done,
   input  logic [SPD_W-1:0] hw_speed,
   output logic             pr,
   output logic             warm,
   output logic             en,
   output logic [SPD_W-1:0] spd,
   output logic             set_pec,
   output logic             set_prc,
   output logic             set_wrc
);
   if (SPEED_MAX < 0 || SPEED_MAX >= (1 << SPD_W)) begin : g_bad
      $error("rport_rstctl: SPEED_MAX out of field range");
   end

   localparam logic [SPD_W-1:0] SMAX = SPD_W'(SPEED_MAX);

   logic             disc, oc_rise, done, en_kill;
   logic [SPD_W-1:0] spd_sel;

   assign disc    = conn_q & ~conn_d;
   assign oc_rise = ~oc_q & oc_d;
   assign done    = rst_done & pr;
   assign en_kill = disc | oc_rise | pwr_off;
   assign spd_sel = (hw_speed > SMAX) ? '0 : hw_speed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pr   <= 1'b0;
         warm <= 1'b0;
      end else if (done) begin
         pr   <= 1'b0;
         warm <= 1'b0;
      end else begin
         if (start_pr | start_warm) pr   <= 1'b1;
         if (start_warm)            warm <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             en <= 1'b0;
      else if (en_kill)       en <= 1'b0;
      else if (done & conn_q) en <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    spd <= '0;
      else if (disc) spd <= '0;
      else if (done) spd <= spd_sel;
   end

   assign set_pec = en & en_kill;
   assign set_prc = done;
   assign set_wrc = done & warm;
endmodule

// File: rtl/rport_ctrl.sv
`timescale 1ns/1ps
module rport_ctrl
   import rport_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         SPEED_MAX   = 4,
   parameter logic       PWR_RST     = 1'b1,
   parameter logic [3:0] LINK_RST    = 4'd5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data,
   input  logic          hw_connect,
   input  logic          hw_overcur,
   input  logic [3:0]    hw_link_state,
   input  logic          link_upd,
   input  logic [3:0]    hw_speed,
   input  logic          reset_done,
   input  logic          cfg_err,
   output logic          port_change
);
   if (LNK_W != 4 || SPD_W != 4) begin : g_bad_w
      $error("rport_ctrl: field widths disagree with port widths");
   end

   logic              conn_q, conn_d, oc_q, oc_d;
   logic              pr, warm, en;
   logic [SPD_W-1:0]  spd;
   logic              set_pec, set_prc, set_wrc;
   logic [LNK_W-1:0]  link;
   logic              pwr;
   logic [N_WAKE-1:0] wake;
   logic [N_CHG-1:0]  chg_set, chg_clr, chg;
   logic              start_pr, start_warm, pwr_off;
   logic              wr_unused;

   assign wr_unused = ^{wr_data[3:0], wr_data[15:10], wr_data[24], wr_data[30:28]};

   rport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_conn_sync (
      .clk(clk), .rst_n(rst_n), .d(hw_connect), .q(conn_q), .q_next(conn_d));

   rport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_oc_sync (
      .clk(clk), .rst_n(rst_n), .d(hw_overcur), .q(oc_q), .q_next(oc_d));

   assign start_pr   = wr_en & pwr & wr_data[B_PR];
   assign start_warm = wr_en & pwr & wr_data[B_WARM];
   assign pwr_off    = wr_en & ~wr_data[B_PWR];

   rport_rstctl #(.SPEED_MAX(SPEED_MAX)) u_rstctl (
      .clk(clk), .rst_n(rst_n),
      .conn_q(conn_q), .conn_d(conn_d), .oc_q(oc_q), .oc_d(oc_d),
      .pwr_off(pwr_off), .start_pr(start_pr), .start_warm(start_warm),
      .rst_done(reset_done), .hw_speed(hw_speed),
      .pr(pr), .warm(warm), .en(en), .spd(spd),
      .set_pec(set_pec), .set_prc(set_prc), .set_wrc(set_wrc));

   // link state: hardware report has priority over a strobed software write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       link <= LINK_RST;
      else if (link_upd)                link <= hw_link_state;
      else if (wr_en & wr_data[B_LSTB]) link <= wr_data[B_LNK_LO +: LNK_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr  <= PWR_RST;
         wake <= '0;
      end else if (wr_en) begin
         pwr  <= wr_data[B_PWR];
         wake <= wr_data[B_WAKE_LO +: N_WAKE];
      end
   end

   always_comb begin
      chg_set           = '0;
      chg_set[CHG_CONN] = conn_d ^ conn_q;
      chg_set[CHG_EN]   = set_pec;
      chg_set[CHG_WARM] = set_wrc;
      chg_set[CHG_OC]   = oc_d ^ oc_q;
      chg_set[CHG_RST]  = set_prc;
      chg_set[CHG_LINK] = link_upd;
      chg_set[CHG_CFG]  = cfg_err;
   end

   assign chg_clr = wr_en ? wr_data[B_CHG_LO +: N_CHG] : '0;

   rport_chg #(.N(N_CHG)) u_chg (
      .clk(clk), .rst_n(rst_n), .set(chg_set), .clr(chg_clr),
      .flags(chg), .any(port_change));

   always_comb begin
      rd_data                          = '0;
      rd_data[B_CONN]                  = conn_q;
      rd_data[B_EN]                    = en;
      rd_data[B_OC]                    = oc_q;
      rd_data[B_PR]                    = pr;
      rd_data[B_LNK_LO +: LNK_W]       = link;
      rd_data[B_PWR]                   = pwr;
      rd_data[B_SPD_LO +: SPD_W]       = spd;
      rd_data[B_CHG_LO +: N_CHG]       = chg;
      rd_data[B_WAKE_LO +: N_WAKE]     = wake;
      rd_data[B_WARM]                  = warm;
   end
endmodule

// File: rtl/rport_ctrl_chk.sv
`timescale 1ns/1ps
module rport_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        wr_stb,
   input logic        link_upd,
   input logic [31:0] rd_data,
   input logic        port_change
);
   p_csc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data[0]) |-> rd_data[17]);

   p_occ_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data[3]) |-> rd_data[20]);

   p_prc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_data[4]) |-> rd_data[21]);

   p_spd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[13:10] <= 4'd4);

   p_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data[8:5]) |-> ($past(link_upd) || ($past(wr_en) && $past(wr_stb))));

   p_wrc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_data[31]) |-> rd_data[19]);

   p_pec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_data[1]) |-> rd_data[18]);

   p_chg_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(port_change) |-> $past(wr_en));
endmodule

bind rport_ctrl rport_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_stb(wr_data[16]),
   .link_upd(link_upd), .rd_data(rd_data), .port_change(port_change));

// File: tb/rport_ctrl_tb.sv
`timescale 1ns/1ps
module rport_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        hw_connect = 1'b0, hw_overcur = 1'b0;
   logic [3:0]  hw_link_state = '0;
   logic        link_upd = 1'b0;
   logic [3:0]  hw_speed = '0;
   logic        reset_done = 1'b0, cfg_err = 1'b0;
   logic        port_change;

   int    checks = 0, errors = 0;
   string cur = "R1";
   bit    finished = 0;

   always #2.5 clk = ~clk;

   rport_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .hw_connect(hw_connect), .hw_overcur(hw_overcur), .hw_link_state(hw_link_state),
      .link_upd(link_upd), .hw_speed(hw_speed), .reset_done(reset_done),
      .cfg_err(cfg_err), .port_change(port_change));

   // behavioural reference state
   bit       m_conn, m_oc, m_en, m_pr, m_wr, m_pwr;
   bit [3:0] m_link, m_spd;
   bit [2:0] m_wake;
   bit [6:0] m_flags;
   bit       cq[$];
   bit       oq[$];

   function automatic bit [31:0] m_rd();
      bit [31:0] r = 0;
      r[0] = m_conn; r[1] = m_en; r[3] = m_oc; r[4] = m_pr;
      r[8:5] = m_link; r[9] = m_pwr; r[13:10] = m_spd;
      r[23:17] = m_flags; r[27:25] = m_wake; r[31] = m_wr;
      return r;
   endfunction

   task automatic model_reset();
      m_conn = 0; m_oc = 0; m_en = 0; m_pr = 0; m_wr = 0; m_pwr = 1;
      m_link = 4'd5; m_spd = 0; m_wake = 0; m_flags = 0;
      cq = '{0}; oq = '{0};
   endtask

   task automatic model_step();
      bit nc, no, disc, ocr, pwroff, done, n_en;
      bit [6:0] set = 0, clr = 0;
      cq.push_back(hw_connect); nc = cq.pop_front();
      oq.push_back(hw_overcur); no = oq.pop_front();
      disc = m_conn && !nc;
      ocr  = !m_oc && no;
      if (nc != m_conn) set[0] = 1;
      if (no != m_oc)   set[3] = 1;
      pwroff = wr_en && !wr_data[9];
      done   = reset_done && m_pr;
      n_en = m_en;
      if (disc || ocr || pwroff) n_en = 0;
      else if (done && m_conn)   n_en = 1;
      if (m_en && !n_en) set[1] = 1;
      if (disc) m_spd = 0;
      else if (done) m_spd = (hw_speed <= 4) ? hw_speed : 4'd0;
      if (done) begin
         set[4] = 1;
         if (m_wr) set[2] = 1;
         m_pr = 0; m_wr = 0;
      end else if (wr_en && m_pwr && (wr_data[4] || wr_data[31])) begin
         m_pr = 1;
         if (wr_data[31]) m_wr = 1;
      end
      if (link_upd) begin
         m_link = hw_link_state; set[5] = 1;
      end else if (wr_en && wr_data[16]) m_link = wr_data[8:5];
      if (cfg_err) set[6] = 1;
      if (wr_en) begin
         m_pwr = wr_data[9]; m_wake = wr_data[27:25]; clr = wr_data[23:17];
      end
      m_en = n_en; m_conn = nc; m_oc = no;
      m_flags = (m_flags & ~clr) | set;
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      if (!rst_n) model_reset(); else model_step();
      @(negedge clk);
      check(cur, rd_data, m_rd());
      check(cur, {31'b0, port_change}, {31'b0, m_flags != 0});
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wr(logic [31:0] d);
      wr_en = 1; wr_data = d; tick(); wr_en = 0; wr_data = '0;
   endtask

   task automatic bits(string req, logic [31:0] mask, logic [31:0] val);
      check(req, rd_data & mask, val);
   endtask

   task automatic finish_rst(logic [3:0] spd);
      hw_speed = spd; reset_done = 1; tick(); reset_done = 0;
   endtask

   initial begin
      model_reset();
      ticks(3);
      rst_n = 1;
      cur = "R1";
      bits("R1", 32'hFFFF_FFFF, 32'h0000_02A0);
      check("R1", {31'b0, port_change}, 32'd0);

      cur = "R2";
      hw_connect = 1; tick();
      bits("R2", 32'h0002_0001, 32'h0);
      tick();
      bits("R2", 32'h0002_0001, 32'h0002_0001);

      cur = "R10";
      check("R10", {31'b0, port_change}, 32'd1);
      wr(32'h0002_0200);
      check("R10", {31'b0, port_change}, 32'd0);

      cur = "R9";
      cfg_err = 1; tick(); cfg_err = 0;
      bits("R9", 32'h0080_0000, 32'h0080_0000);
      wr(32'h0000_0200);
      bits("R9", 32'h0080_0000, 32'h0080_0000);
      cfg_err = 1; wr(32'h0080_0200); cfg_err = 0;
      bits("R9", 32'h0080_0000, 32'h0080_0000);
      wr(32'h0080_0200);
      bits("R9", 32'h0080_0000, 32'h0);

      cur = "R4";
      wr(32'h0000_0210);
      bits("R4", 32'h10, 32'h10);
      ticks(3);
      bits("R4", 32'h0020_0012, 32'h10);
      finish_rst(4'd3);
      bits("R4", 32'h0020_3C12, 32'h0020_0C02);
      wr(32'h0020_0200);

      cur = "R11";
      wr(32'h7F00_C204);
      bits("R11", 32'h7F01_C204, 32'h0E00_0200);
      wr(32'h0000_0200);
      bits("R11", 32'h0E00_0000, 32'h0);

      cur = "R6";
      wr(32'h0000_0200 | (32'd9 << 5));
      bits("R6", 32'h0001_01E0, 32'h0A0);
      wr(32'h0001_0200 | (32'd9 << 5));
      bits("R6", 32'h0001_01E0, 32'h120);
      hw_link_state = 4'd3; link_upd = 1;
      wr(32'h0001_0200 | (32'd7 << 5));
      link_upd = 0;
      bits("R6", 32'h0041_01E0, 32'h0040_0060);
      wr(32'h0040_0200);

      cur = "R8";
      hw_connect = 0; ticks(2);
      bits("R8", 32'h0006_3C03, 32'h0006_0000);
      cur = "R5";
      bits("R5", 32'h3C00, 32'h0);
      wr(32'h0006_0200);

      hw_connect = 1; ticks(2);
      wr(32'h0002_0210);
      finish_rst(4'd9);
      bits("R5", 32'h0000_3C12, 32'h0000_0002);
      wr(32'h0020_0200);

      cur = "R3";
      hw_overcur = 1; tick();
      bits("R3", 32'h0010_0008, 32'h0);
      tick();
      bits("R3", 32'h0014_000A, 32'h0014_0008);
      hw_overcur = 0; ticks(2);
      bits("R3", 32'h0010_0008, 32'h0010_0000);
      wr(32'h0014_0200);

      cur = "R7";
      wr(32'h8000_0200);
      bits("R7", 32'h8000_0010, 32'h8000_0010);
      ticks(2);
      finish_rst(4'd4);
      bits("R7", 32'h8028_3C12, 32'h0028_1002);
      wr(32'h0028_0200);

      cur = "R8";
      wr(32'h0000_0000);
      bits("R8", 32'h0004_0202, 32'h0004_0000);
      cur = "R4";
      wr(32'h0000_0010);
      bits("R4", 32'h10, 32'h0);

      cur = "R10";
      check("R10", {31'b0, port_change}, 32'd1);
      wr(32'h00FE_0200);
      check("R10", {31'b0, port_change}, 32'd0);
      ticks(2);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule